// File: doc/BRIEF.md
# Automatic Polling Status Matcher

This block sits beside a polling sequencer that repeatedly reads a status word from an external memory device. Each returned word arrives with a one-cycle valid strobe. The block compares the word against a programmed match value, and only the bit positions selected by a mask take part. When the comparison succeeds, the block raises a sticky match flag and an optional interrupt, and it tells the sequencer whether to keep polling.

A mode input selects the comparison rule. In all-bits mode, every selected bit must agree with the match value. In any-bit mode, a single agreeing selected bit is enough. A second control input decides what a match does to polling. Polling either halts at the first match, with a one-cycle completion pulse, or it keeps running after matches until it is aborted or the block is disabled. Polling begins on a start pulse. Status words that arrive while polling is not running are discarded.

Top module: `status_poll_matcher`

## Requirements
- R1: With `or_mode_i` = 0, a valid status word matches when `((status ^ match_val) & mask) == 0`.
- R2: With `or_mode_i` = 1, a valid status word matches when `(~(status ^ match_val) & mask) != 0`.
- R3: Bit positions whose mask bit is 0 never affect the result. In any-bit mode, an all-zero mask never produces a match.
- R4: With `stop_on_match_i` = 1, a match clears `active_o` at the same clock edge that sets `match_flag_o`. At that edge `done_o` also rises, and it stays high for exactly one cycle.
- R5: With `stop_on_match_i` = 0, matches leave `active_o` set and do not raise `done_o`. Polling then ends only when an abort is taken or `enable_i` is low, and `active_o` drops one cycle after `enable_i` goes low.
- R6: `match_irq_o` is high exactly when `match_flag_o` and `match_ie_i` are both high.
- R7: `match_flag_o` stays set until `flag_clr_i` is sampled high. When a new match and a clear fall on the same edge, the flag stays set.
- R8: A comparison takes place only on an edge where `status_valid_i` is high and `active_o` is high. Status words presented at any other time leave the flag unchanged.
- R9: An `abort_i` pulse makes `abort_pend_o` high for one cycle. At the following edge, `abort_pend_o` clears itself and `active_o` becomes 0.
- R10: A `start_i` pulse sets `active_o` at the next edge only if `enable_i` is high and no abort is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Peripheral enable. Low stops polling |
| start_i | input | 1 | Start pulse that begins polling |
| abort_i | input | 1 | Abort request pulse |
| status_i | input | STATUS_W | Status word read back from the device |
| status_valid_i | input | 1 | Strobe marking `status_i` as valid |
| mask_i | input | STATUS_W | Selects the bits that take part in the comparison |
| match_val_i | input | STATUS_W | Expected bit values |
| or_mode_i | input | 1 | 0 = all-bits match, 1 = any-bit match |
| stop_on_match_i | input | 1 | 1 = halt polling at the first match |
| match_ie_i | input | 1 | Match interrupt enable |
| flag_clr_i | input | 1 | Write-one-to-clear for the match flag |
| match_flag_o | output | 1 | Sticky match flag |
| match_irq_o | output | 1 | Match interrupt |
| active_o | output | 1 | Polling is running |
| done_o | output | 1 | One-cycle pulse when polling halts on a match |
| abort_pend_o | output | 1 | Abort in progress. Clears itself |

## Verification
The bench builds the block with `STATUS_W` = 4. With that width it can sweep every combination of status, mask and match value under both comparison modes, which is 8192 cases. Each predicted result is worked out arithmetically from R1 and R2. Because the sweep is exhaustive, it reaches the all-zero mask, the all-ones mask and every partial mask. It therefore checks both the behaviour of ignored bits and the fact that an empty mask never matches in any-bit mode. Directed sequences then cover continued polling, abort, disable, clear priority, interrupt gating and status words that arrive while polling is idle.

// File: rtl/poll_match_pkg.sv
package poll_match_pkg;
  typedef enum logic {MATCH_ALL = 1'b0, MATCH_ANY = 1'b1} match_mode_e;
  typedef enum logic {ST_IDLE = 1'b0, ST_POLL = 1'b1} poll_state_e;
endpackage

// File: rtl/poll_compare.sv
module poll_compare
  import poll_match_pkg::*;
#(
  parameter int STATUS_W = 32
) (
  input  logic [STATUS_W-1:0] status_i,
  input  logic [STATUS_W-1:0] mask_i,
  input  logic [STATUS_W-1:0] match_val_i,
  input  match_mode_e         mode_i,
  output logic                hit_o
);
  logic [STATUS_W-1:0] all_term;
  logic [STATUS_W-1:0] any_term;

  for (genvar b = 0; b < STATUS_W; b++) begin : g_bit
    logic same;
    assign same        = ~(status_i[b] ^ match_val_i[b]);
    // unmasked bit passes in all-mode, never contributes in any-mode
    assign all_term[b] = same | ~mask_i[b];
    assign any_term[b] = same & mask_i[b];
  end

  always_comb begin
    unique case (mode_i)
      MATCH_ALL: hit_o = &all_term;
      MATCH_ANY: hit_o = |any_term;
      default:   hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/poll_ctrl.sv
module poll_ctrl
  import poll_match_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic start_i,
  input  logic abort_i,
  input  logic status_valid_i,
  input  logic hit_i,
  input  logic stop_on_match_i,
  input  logic flag_clr_i,
  output logic match_flag_o,
  output logic active_o,
  output logic done_o,
  output logic abort_pend_o
);
  poll_state_e state_q, state_d;
  logic        flag_q, done_q, pend_q;
  logic        take, halt_match;

  assign take       = (state_q == ST_POLL) && status_valid_i;
  assign halt_match = take && hit_i && stop_on_match_i;

  always_comb begin
    state_d = state_q;
    if (!enable_i || pend_q)                         state_d = ST_IDLE;
    else if (state_q == ST_POLL && halt_match)       state_d = ST_IDLE;
    else if (state_q == ST_IDLE && start_i)          state_d = ST_POLL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      flag_q  <= 1'b0;
      done_q  <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= enable_i && !pend_q && halt_match;
      pend_q  <= abort_i;
      // set wins over clear
      if (take && hit_i)   flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
    end
  end

  assign match_flag_o = flag_q;
  assign active_o     = (state_q == ST_POLL);
  assign done_o       = done_q;
  assign abort_pend_o = pend_q;

  // R4
  done_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R4
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !active_o);
  // R5
  disable_stops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !active_o);
  // R9
  abort_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_pend_o && !abort_i) |=> (!abort_pend_o && !active_o));
  // R10
  start_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> $past(start_i && enable_i));
  // R8
  flag_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(match_flag_o) |-> $past(status_valid_i && active_o));
  // R7
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_flag_o && !flag_clr_i) |=> match_flag_o);
endmodule

// File: rtl/status_poll_matcher.sv
module status_poll_matcher
  import poll_match_pkg::*;
#(
  parameter int STATUS_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                enable_i,
  input  logic                start_i,
  input  logic                abort_i,
  input  logic [STATUS_W-1:0] status_i,
  input  logic                status_valid_i,
  input  logic [STATUS_W-1:0] mask_i,
  input  logic [STATUS_W-1:0] match_val_i,
  input  logic                or_mode_i,
  input  logic                stop_on_match_i,
  input  logic                match_ie_i,
  input  logic                flag_clr_i,
  output logic                match_flag_o,
  output logic                match_irq_o,
  output logic                active_o,
  output logic                done_o,
  output logic                abort_pend_o
);
  logic        hit;
  match_mode_e mode;

  assign mode = match_mode_e'(or_mode_i);

  poll_compare #(.STATUS_W(STATUS_W)) cmp_i (
    .status_i    (status_i),
    .mask_i      (mask_i),
    .match_val_i (match_val_i),
    .mode_i      (mode),
    .hit_o       (hit)
  );

  poll_ctrl ctrl_i (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .enable_i        (enable_i),
    .start_i         (start_i),
    .abort_i         (abort_i),
    .status_valid_i  (status_valid_i),
    .hit_i           (hit),
    .stop_on_match_i (stop_on_match_i),
    .flag_clr_i      (flag_clr_i),
    .match_flag_o    (match_flag_o),
    .active_o        (active_o),
    .done_o          (done_o),
    .abort_pend_o    (abort_pend_o)
  );

  assign match_irq_o = match_flag_o & match_ie_i;

  // R3
  empty_mask_any_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (or_mode_i && mask_i == '0) |-> !hit);
  // R6
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_irq_o |-> (match_flag_o && match_ie_i));
endmodule

// File: tb/status_poll_matcher_tb.sv
module status_poll_matcher_tb_top;
  localparam int W = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b0, start = 1'b0, abrt = 1'b0, vld = 1'b0;
  logic [W-1:0] st = '0, msk = '0, mv = '0;
  logic orm = 1'b0, som = 1'b0, ie = 1'b0, clr = 1'b0;
  logic flag, irq, act, done, pend;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  status_poll_matcher #(.STATUS_W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .start_i(start), .abort_i(abrt),
    .status_i(st), .status_valid_i(vld), .mask_i(msk), .match_val_i(mv),
    .or_mode_i(orm), .stop_on_match_i(som), .match_ie_i(ie), .flag_clr_i(clr),
    .match_flag_o(flag), .match_irq_o(irq), .active_o(act), .done_o(done),
    .abort_pend_o(pend));

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string req, int act_v, int exp_v);
    checks++;
    if (act_v != exp_v) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
    end
  endtask

  task automatic reset_poll();
    abrt = 1'b1; clr = 1'b1; tick();
    abrt = 1'b0; clr = 1'b0; tick();
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R4 reset", {flag, irq, act, done, pend}, 0);
    rst_n = 1'b1; en = 1'b1; tick();

    // R1 R2 R3 R4 exhaustive sweep, stop at first match
    som = 1'b1;
    for (int m = 0; m < 2; m++)
      for (int k = 0; k < 16; k++)
        for (int v = 0; v < 16; v++)
          for (int s = 0; s < 16; s++) begin
            bit exp;
            string req;
            exp = m ? (((~(s ^ v)) & k & 15) != 0) : (((s ^ v) & k) == 0);
            req = (k == 0) ? "R3" : (m ? "R2" : "R1");
            orm = m[0]; msk = k[W-1:0]; mv = v[W-1:0];
            start = 1'b1; tick(); start = 1'b0;
            st = s[W-1:0]; vld = 1'b1; tick(); vld = 1'b0;
            chk(req, flag, exp);
            chk("R4", {done, act}, exp ? 2 : 1);
            tick();
            chk("R4 pulse", done, 0);
            reset_poll();
          end

    // R5 continued polling
    som = 1'b0; orm = 1'b0; msk = 4'hF; mv = 4'hA;
    start = 1'b1; tick(); start = 1'b0;
    st = 4'hA; vld = 1'b1; tick(); vld = 1'b0;
    chk("R5 flag", flag, 1);
    chk("R5 keeps polling", {act, done}, 2);
    vld = 1'b1; tick(); vld = 1'b0;
    chk("R5 second match", {act, done}, 2);
    en = 1'b0; tick();
    chk("R5 disable", act, 0);
    en = 1'b1; clr = 1'b1; tick(); clr = 1'b0;

    // R10 start ignored while disabled
    en = 1'b0; start = 1'b1; tick(); start = 1'b0; en = 1'b1;
    chk("R10", act, 0);

    // R8 idle status ignored
    st = 4'hA; vld = 1'b1; tick(); vld = 1'b0;
    chk("R8 idle", flag, 0);
    start = 1'b1; tick(); start = 1'b0;
    tick();
    chk("R8 no strobe", flag, 0);

    // R7 set wins over clear, then clear
    vld = 1'b1; tick();
    clr = 1'b1; tick(); vld = 1'b0;
    chk("R7 set wins", flag, 1);
    tick(); clr = 1'b0;
    chk("R7 clear", flag, 0);
    vld = 1'b1; tick(); vld = 1'b0;
    tick();
    chk("R7 sticky", flag, 1);

    // R6 interrupt gating
    ie = 1'b0; #1;
    chk("R6 masked", irq, 0);
    ie = 1'b1; #1;
    chk("R6 enabled", irq, 1);
    clr = 1'b1; tick(); clr = 1'b0;
    chk("R6 cleared", irq, 0);

    // R9 abort
    chk("R9 pre", act, 1);
    abrt = 1'b1; tick(); abrt = 1'b0;
    chk("R9 pending", {pend, act}, 3);
    tick();
    chk("R9 complete", {pend, act}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule